// File: doc/BRIEF.md
# Processing-State and Exception Sequencer

This block keeps track of the processing state of a small processor core and carries out the memory traffic that exception entry needs. It holds the core in reset while the active-low reset input is low. It notes whether the reset is a power-on reset or a manual reset from the NMI level. After reset it fetches the start PC and the initial stack pointer from the vector table, then hands control to the instruction datapath.

While the core runs, the sequencer takes interrupts at instruction boundaries. It saves SR and PC on a downward-growing stack and loads the handler address from the vector table. It also handles the SLEEP instruction strobe, which leads to either light sleep or standby. It wakes the core from those modes and releases the bus to an external master on request.

All memory traffic goes through one single-word request/acknowledge port, with at most one access outstanding.

Top module: `cpu_state_seq`

## Requirements
- R1: While `cpu_reset_n` is low, `proc_state` is 0 (RESET), `mem_req`, `bus_grant` and `cpu_run` are 0, `periph_en` is 1, and `reset_kind` follows `nmi_in` (1 = power-on, 0 = manual).
- R2: After reset is released, the block reads two words and then enters RUN (`proc_state` 2, `cpu_run` 1). A power-on reset reads `VEC_BASE+0` into PC and then `VEC_BASE+4` into SP. A manual reset reads `VEC_BASE+8` into PC and then `VEC_BASE+12` into SP.
- R3: Exception handling (`proc_state` 1) is transient, and it always ends in RUN.
- R4: In RUN, `irq_pending` together with `insn_boundary` starts exception handling, which makes three accesses in this order. It writes `cur_sr` at SP-4, then writes `cur_pc` at SP-8, then reads `VEC_BASE+4*irq_vector` into PC. SP then becomes SP-8. `cur_pc`, `cur_sr` and `irq_vector` are captured in the cycle the exception is taken.
- R5: In RUN, `sleep_strobe` with `sby_bit`=0 enters SLEEP (`proc_state` 3). `periph_en` stays 1, `cpu_run` goes to 0, and no memory access is made.
- R6: In RUN, `sleep_strobe` with `sby_bit`=1 enters STANDBY (`proc_state` 4) and drives `periph_en` to 0. `irq_pending` has no effect there. A rising edge of `nmi_in` takes exception handling through vector `NMI_VEC` and drives `periph_en` back to 1.
- R7: In SLEEP, `irq_pending` starts exception handling with `irq_vector` (same accesses as R4), and no instruction boundary is needed.
- R8: `bus_req` is granted from RUN at an instruction boundary, or at any time from SLEEP. The block then enters BUS-RELEASED (`proc_state` 5) with `bus_grant` 1. When `bus_req` drops, it returns to the state it came from and `bus_grant` returns to 0.
- R9: A bus request is never granted during exception handling, and `mem_req` is only ever high during exception handling.
- R10: Once raised, `mem_req` keeps its address, direction and write data until `mem_ack`, and each access is made exactly once.
- R11: In RUN, with several requests in the same cycle, a bus request wins over an interrupt, and an interrupt wins over `sleep_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cpu_reset_n | input | 1 | Synchronous active-low reset; holds the block in RESET |
| nmi_in | input | 1 | NMI level: selects reset kind; rising edge wakes standby |
| sby_bit | input | 1 | Standby select applied when SLEEP executes |
| sleep_strobe | input | 1 | One-cycle strobe of a SLEEP instruction |
| insn_boundary | input | 1 | High when the datapath is between instructions |
| irq_pending | input | 1 | An interrupt is waiting |
| irq_vector | input | VEC_W | Vector number of the waiting interrupt |
| cur_pc | input | AW | PC to save when an exception is taken |
| cur_sr | input | DW | SR to save when an exception is taken |
| bus_req | input | 1 | External master requests the bus |
| bus_grant | output | 1 | Bus handed to the external master |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current access |
| proc_state | output | 3 | 0 reset, 1 exception, 2 run, 3 sleep, 4 standby, 5 bus released |
| reset_kind | output | 1 | 1 = power-on reset, 0 = manual reset |
| periph_en | output | 1 | Peripheral enable, low only in standby |
| cpu_run | output | 1 | Instruction execution allowed |
| pc_load | output | 1 | One-cycle pulse when pc_value is freshly loaded |
| pc_value | output | AW | PC loaded from the vector table |
| sp_value | output | AW | Current stack pointer |

## Verification
The hardest situation to reach is a bus request that arrives during the stacking sequence. It must wait until exception handling has finished and the core is back at an instruction boundary. To reach it, the stimulus starts an interrupt and raises the bus request in the very next cycle, while the memory model stretches each access by a random number of cycles. The stimulus also holds the boundary input high throughout, so the request is granted in the first cycle after the return to RUN. Separate runs cover the priority case, where bus request, interrupt and SLEEP all arrive together, and the standby wake-up, where interrupts must be ignored until an NMI edge.

// File: rtl/cps_pkg.sv
package cps_pkg;
  // Processing-state encoding, visible on proc_state.
  typedef enum logic [2:0] {
    PS_RESET  = 3'd0,
    PS_EXC    = 3'd1,
    PS_RUN    = 3'd2,
    PS_SLEEP  = 3'd3,
    PS_STBY   = 3'd4,
    PS_BUSREL = 3'd5
  } pstate_e;

  // Kind of exception sequence the engine runs.
  typedef enum logic [1:0] {
    XK_POWERON = 2'd0,
    XK_MANUAL  = 2'd1,
    XK_IRQ     = 2'd2
  } xkind_e;

  // Phases of the exception engine.
  typedef enum logic [1:0] {
    EP_IDLE  = 2'd0,
    EP_ISSUE = 2'd1,
    EP_WAIT  = 2'd2
  } eng_phase_e;
endpackage

// File: rtl/cps_vec_addr.sv
module cps_vec_addr #(
  parameter int              AW       = 32,
  parameter int              VEC_W    = 6,
  parameter logic [AW-1:0]   VEC_BASE = '0
) (
  input  logic [VEC_W-1:0] vec_num,
  output logic [AW-1:0]    vec_addr
);
  // One 4-byte word per vector entry.
  localparam int ENTRY_SHIFT = 2;

  assign vec_addr = VEC_BASE + (AW'(vec_num) << ENTRY_SHIFT);
endmodule

// File: rtl/cps_mem_port.sv
module cps_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          acc_done,
  output logic [DW-1:0] acc_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_done <= 1'b0;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req   <= 1'b0;
          acc_done  <= 1'b1;
          acc_rdata <= mem_rdata;
        end
      end else if (go) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we;
        mem_addr  <= go_addr;
        mem_wdata <= go_wdata;
      end
    end
  end

  // R10: an open request holds its address, direction and data until acknowledged.
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: a new access is only started while none is open.
  a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !mem_req);
endmodule

// File: rtl/cps_exc_engine.sv
module cps_exc_engine
  import cps_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            VEC_W    = 6,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  xkind_e           start_kind,
  input  logic [VEC_W-1:0] start_vec,
  input  logic [AW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_sr,
  output logic             go,
  output logic             go_we,
  output logic [AW-1:0]    go_addr,
  output logic [DW-1:0]    go_wdata,
  input  logic             acc_done,
  input  logic [DW-1:0]    acc_rdata,
  output logic             done,
  output logic             pc_load,
  output logic [AW-1:0]    pc_value,
  output logic [AW-1:0]    sp_value
);
  localparam int STK_BYTES      = 4;
  localparam int MANUAL_VEC_OFS = 2;

  eng_phase_e       phase_q;
  xkind_e           kind_q;
  logic [1:0]       step_q;
  logic [VEC_W-1:0] vec_q;
  logic [AW-1:0]    pc_save_q;
  logic [DW-1:0]    sr_save_q;
  logic [AW-1:0]    sp_q;
  logic [AW-1:0]    pc_q;

  logic             is_irq;
  logic             last_step;
  logic [VEC_W-1:0] vec_sel;
  logic [AW-1:0]    vec_addr;

  assign is_irq    = (kind_q == XK_IRQ);
  assign last_step = is_irq ? (step_q == 2'd2) : (step_q == 2'd1);

  always_comb begin
    case (kind_q)
      XK_POWERON: vec_sel = VEC_W'(step_q);
      XK_MANUAL:  vec_sel = VEC_W'(MANUAL_VEC_OFS) + VEC_W'(step_q);
      default:    vec_sel = vec_q;
    endcase
  end

  cps_vec_addr #(.AW(AW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec_addr (
    .vec_num  (vec_sel),
    .vec_addr (vec_addr)
  );

  // Access for the current step: SR push, PC push, then vector read.
  always_comb begin
    if (is_irq && step_q == 2'd0) begin
      go_we    = 1'b1;
      go_addr  = sp_q - AW'(STK_BYTES);
      go_wdata = sr_save_q;
    end else if (is_irq && step_q == 2'd1) begin
      go_we    = 1'b1;
      go_addr  = sp_q - AW'(2 * STK_BYTES);
      go_wdata = DW'(pc_save_q);
    end else begin
      go_we    = 1'b0;
      go_addr  = vec_addr;
      go_wdata = '0;
    end
  end

  assign go = (phase_q == EP_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= EP_IDLE;
      kind_q    <= XK_POWERON;
      step_q    <= 2'd0;
      vec_q     <= '0;
      pc_save_q <= '0;
      sr_save_q <= '0;
      sp_q      <= '0;
      pc_q      <= '0;
      done      <= 1'b0;
      pc_load   <= 1'b0;
    end else begin
      done    <= 1'b0;
      pc_load <= 1'b0;
      case (phase_q)
        EP_IDLE: begin
          if (start) begin
            kind_q    <= start_kind;
            vec_q     <= start_vec;
            pc_save_q <= cur_pc;
            sr_save_q <= cur_sr;
            step_q    <= 2'd0;
            phase_q   <= EP_ISSUE;
          end
        end
        EP_ISSUE: phase_q <= EP_WAIT;
        EP_WAIT: begin
          if (acc_done) begin
            if (!go_we) begin
              if (is_irq || step_q == 2'd0) pc_q <= AW'(acc_rdata);
              else                          sp_q <= AW'(acc_rdata);
            end
            if (last_step) begin
              done    <= 1'b1;
              pc_load <= 1'b1;
              if (is_irq) sp_q <= sp_q - AW'(2 * STK_BYTES);
              phase_q <= EP_IDLE;
            end else begin
              step_q  <= step_q + 2'd1;
              phase_q <= EP_ISSUE;
            end
          end
        end
        default: phase_q <= EP_IDLE;
      endcase
    end
  end

  assign pc_value = pc_q;
  assign sp_value = sp_q;

  // R3: completion is a single-cycle event.
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: an interrupt sequence lowers SP by exactly two stack words.
  a_r4_sp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_irq) |-> (sp_q == $past(sp_q) - AW'(2 * STK_BYTES)));
endmodule

// File: rtl/cpu_state_seq.sv
module cpu_state_seq
  import cps_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            VEC_W    = 6,
  parameter logic [AW-1:0] VEC_BASE = 32'h0000_0100,
  parameter int            NMI_VEC  = 11
) (
  input  logic             clk,
  input  logic             cpu_reset_n,
  input  logic             nmi_in,
  input  logic             sby_bit,
  input  logic             sleep_strobe,
  input  logic             insn_boundary,
  input  logic             irq_pending,
  input  logic [VEC_W-1:0] irq_vector,
  input  logic [AW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_sr,
  input  logic             bus_req,
  output logic             bus_grant,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic [2:0]       proc_state,
  output logic             reset_kind,
  output logic             periph_en,
  output logic             cpu_run,
  output logic             pc_load,
  output logic [AW-1:0]    pc_value,
  output logic [AW-1:0]    sp_value
);
  pstate_e          st_q, st_d, ret_q, ret_d;
  logic             nmi_q, nmi_rise;
  logic             reset_kind_q, periph_q, run_q, grant_q;
  logic             eng_start, eng_done;
  xkind_e           eng_kind;
  logic [VEC_W-1:0] eng_vec;

  logic             go, go_we, acc_done;
  logic [AW-1:0]    go_addr;
  logic [DW-1:0]    go_wdata, acc_rdata;

  assign nmi_rise = nmi_in & ~nmi_q;

  // Processing-state transitions; priority in RUN: bus, interrupt, sleep.
  always_comb begin
    st_d      = st_q;
    ret_d     = ret_q;
    eng_start = 1'b0;
    eng_kind  = XK_IRQ;
    eng_vec   = irq_vector;
    case (st_q)
      PS_RESET: begin
        eng_start = 1'b1;
        eng_kind  = reset_kind_q ? XK_POWERON : XK_MANUAL;
        st_d      = PS_EXC;
      end
      PS_EXC: if (eng_done) st_d = PS_RUN;
      PS_RUN: begin
        if (insn_boundary && bus_req) begin
          st_d  = PS_BUSREL;
          ret_d = PS_RUN;
        end else if (insn_boundary && irq_pending) begin
          eng_start = 1'b1;
          st_d      = PS_EXC;
        end else if (sleep_strobe) begin
          st_d = sby_bit ? PS_STBY : PS_SLEEP;
        end
      end
      PS_SLEEP: begin
        if (bus_req) begin
          st_d  = PS_BUSREL;
          ret_d = PS_SLEEP;
        end else if (irq_pending) begin
          eng_start = 1'b1;
          st_d      = PS_EXC;
        end
      end
      PS_STBY: begin
        if (nmi_rise) begin
          eng_start = 1'b1;
          eng_vec   = VEC_W'(NMI_VEC);
          st_d      = PS_EXC;
        end
      end
      PS_BUSREL: if (!bus_req) st_d = ret_q;
      default: st_d = PS_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!cpu_reset_n) begin
      st_q         <= PS_RESET;
      ret_q        <= PS_RUN;
      reset_kind_q <= nmi_in;
      periph_q     <= 1'b1;
      run_q        <= 1'b0;
      grant_q      <= 1'b0;
      nmi_q        <= nmi_in;
    end else begin
      st_q     <= st_d;
      ret_q    <= ret_d;
      periph_q <= (st_d != PS_STBY);
      run_q    <= (st_d == PS_RUN);
      grant_q  <= (st_d == PS_BUSREL);
      nmi_q    <= nmi_in;
    end
  end

  cps_exc_engine #(.AW(AW), .DW(DW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_engine (
    .clk        (clk),
    .rst_n      (cpu_reset_n),
    .start      (eng_start),
    .start_kind (eng_kind),
    .start_vec  (eng_vec),
    .cur_pc     (cur_pc),
    .cur_sr     (cur_sr),
    .go         (go),
    .go_we      (go_we),
    .go_addr    (go_addr),
    .go_wdata   (go_wdata),
    .acc_done   (acc_done),
    .acc_rdata  (acc_rdata),
    .done       (eng_done),
    .pc_load    (pc_load),
    .pc_value   (pc_value),
    .sp_value   (sp_value)
  );

  cps_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (cpu_reset_n),
    .go        (go),
    .go_we     (go_we),
    .go_addr   (go_addr),
    .go_wdata  (go_wdata),
    .acc_done  (acc_done),
    .acc_rdata (acc_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  assign proc_state = st_q;
  assign reset_kind = reset_kind_q;
  assign periph_en  = periph_q;
  assign cpu_run    = run_q;
  assign bus_grant  = grant_q;

  // R9: memory traffic only happens while exceptions are handled.
  a_r9_mem_only_in_exc: assert property (@(posedge clk) disable iff (!cpu_reset_n)
    mem_req |-> (st_q == PS_EXC));

  // R3: leaving exception handling always lands in RUN.
  a_r3_exc_exit_run: assert property (@(posedge clk) disable iff (!cpu_reset_n)
    ($past(st_q) == PS_EXC && st_q != PS_EXC) |-> (st_q == PS_RUN));

  // R8: a grant only follows a request.
  a_r8_grant_after_req: assert property (@(posedge clk) disable iff (!cpu_reset_n)
    $rose(bus_grant) |-> $past(bus_req));

  // R6: without an NMI edge, standby is kept whatever else arrives.
  a_r6_standby_holds: assert property (@(posedge clk) disable iff (!cpu_reset_n)
    (st_q == PS_STBY && !nmi_rise) |=> (st_q == PS_STBY));
endmodule

// File: tb/test_cpu_state_seq.sv
module test_cpu_state_seq;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW = 32;
  localparam int          DW = 32;
  localparam int          VEC_W = 6;
  localparam logic [31:0] VEC_BASE = 32'h0000_0100;
  localparam int          NMI_VEC = 11;

  logic clk = 1'b0;
  logic cpu_reset_n, nmi_in, sby_bit, sleep_strobe, insn_boundary, irq_pending;
  logic [VEC_W-1:0] irq_vector;
  logic [AW-1:0] cur_pc;
  logic [DW-1:0] cur_sr;
  logic bus_req, bus_grant, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [2:0] proc_state;
  logic reset_kind, periph_en, cpu_run, pc_load;
  logic [AW-1:0] pc_value, sp_value;

  int n_checks = 0;
  int n_err = 0;
  logic [31:0] exp_sp;

  logic [31:0] log_addr [0:15];
  logic [31:0] log_data [0:15];
  logic        log_we   [0:15];
  int          log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_state_seq #(.AW(AW), .DW(DW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC)) i_cpu_state_seq (
    .clk(clk), .cpu_reset_n(cpu_reset_n), .nmi_in(nmi_in), .sby_bit(sby_bit),
    .sleep_strobe(sleep_strobe), .insn_boundary(insn_boundary), .irq_pending(irq_pending),
    .irq_vector(irq_vector), .cur_pc(cur_pc), .cur_sr(cur_sr), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .proc_state(proc_state), .reset_kind(reset_kind), .periph_en(periph_en),
    .cpu_run(cpu_run), .pc_load(pc_load), .pc_value(pc_value), .sp_value(sp_value)
  );

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return 32'h4000_0000 ^ (a << 4);
  endfunction

  function automatic logic [31:0] vaddr(input int n);
    return VEC_BASE + 32'(n) * 32'd4;
  endfunction

  // Memory model with random acknowledge latency; logs each access once.
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req && ($urandom_range(0, 2) != 0)) begin
      mem_ack = 1'b1;
      if (log_n < 16) begin
        log_addr[log_n] = mem_addr;
        log_we[log_n]   = mem_we;
        log_data[log_n] = mem_we ? mem_wdata : rd_word(mem_addr);
        log_n++;
      end
      if (!mem_we) mem_rdata = rd_word(mem_addr);
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic wait_state(input logic [2:0] tgt, input string what);
    for (int k = 0; k < 300 && proc_state !== tgt; k++) @(negedge clk);
    check(proc_state === tgt, what, 32'(proc_state), 32'(tgt));
  endtask

  task automatic verify_exc(input int vec, input logic [31:0] pc, input logic [31:0] sr, input string tag);
    check(log_n == 3, {tag, " access count"}, 32'(log_n), 32'd3);
    check(log_we[0] && log_addr[0] == exp_sp - 4 && log_data[0] == sr, {tag, " SR push (R4)"}, log_addr[0], exp_sp - 4);
    check(log_we[1] && log_addr[1] == exp_sp - 8 && log_data[1] == pc, {tag, " PC push (R4)"}, log_data[1], pc);
    check(!log_we[2] && log_addr[2] == vaddr(vec), {tag, " vector read (R4)"}, log_addr[2], vaddr(vec));
    exp_sp = exp_sp - 8;
    check(pc_value == rd_word(vaddr(vec)), {tag, " PC load"}, pc_value, rd_word(vaddr(vec)));
    check(sp_value == exp_sp, {tag, " SP update (R4)"}, sp_value, exp_sp);
  endtask

  task automatic do_reset(input logic nmi_level);
    @(negedge clk);
    nmi_in = nmi_level;
    cpu_reset_n = 1'b0;
    repeat (3) @(negedge clk);
    check(proc_state == 3'd0 && !mem_req && !bus_grant && !cpu_run && periph_en,
          "R1 outputs in reset", {27'd0, proc_state, mem_req, bus_grant}, 32'd0);
    check(reset_kind == nmi_level, "R1 reset kind", 32'(reset_kind), 32'(nmi_level));
    log_n = 0;
    cpu_reset_n = 1'b1;
    wait_state(3'd2, "R2 reach RUN after reset");
    check(log_n == 2 && !log_we[0] && !log_we[1], "R2 two reads", 32'(log_n), 32'd2);
    check(log_addr[0] == vaddr(nmi_level ? 0 : 2), "R2 PC vector address", log_addr[0], vaddr(nmi_level ? 0 : 2));
    check(log_addr[1] == vaddr(nmi_level ? 1 : 3), "R2 SP vector address", log_addr[1], vaddr(nmi_level ? 1 : 3));
    check(pc_value == rd_word(vaddr(nmi_level ? 0 : 2)), "R2 start PC", pc_value, rd_word(vaddr(nmi_level ? 0 : 2)));
    check(sp_value == rd_word(vaddr(nmi_level ? 1 : 3)), "R2 initial SP", sp_value, rd_word(vaddr(nmi_level ? 1 : 3)));
    check(cpu_run == 1'b1, "R3 run after reset sequence", 32'(cpu_run), 32'd1);
    exp_sp = rd_word(vaddr(nmi_level ? 1 : 3));
  endtask

  // Interrupt from RUN (needs boundary) or from SLEEP.
  task automatic do_irq(input int vec, input logic [31:0] pc, input logic [31:0] sr, input string tag);
    @(negedge clk);
    cur_pc = pc; cur_sr = sr; irq_vector = VEC_W'(vec);
    irq_pending = 1'b1; insn_boundary = 1'b1;
    log_n = 0;
    @(negedge clk);
    check(proc_state == 3'd1, {tag, " enters exception"}, 32'(proc_state), 32'd1);
    irq_pending = 1'b0; insn_boundary = 1'b0;
    cur_pc = $urandom; cur_sr = $urandom; irq_vector = VEC_W'($urandom);
    wait_state(3'd2, {tag, " back to RUN (R3)"});
    verify_exc(vec, pc, sr, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int dummy;
    int bad;
    logic [31:0] pc_r, sr_r;
    dummy = $urandom(32'd1357);
    cpu_reset_n = 1'b0; nmi_in = 1'b1; sby_bit = 1'b0; sleep_strobe = 1'b0;
    insn_boundary = 1'b0; irq_pending = 1'b0; irq_vector = '0; cur_pc = '0; cur_sr = '0;
    bus_req = 1'b0; mem_ack = 1'b0; mem_rdata = '0;

    do_reset(1'b1);   // power-on
    do_reset(1'b0);   // manual
    nmi_in = 1'b0;

    // R4: random interrupts in RUN
    for (int i = 0; i < 12; i++) begin
      do_irq($urandom_range(0, 63), $urandom, $urandom, "R4 random irq");
    end

    // R5: sleep
    @(negedge clk); sby_bit = 1'b0; sleep_strobe = 1'b1; log_n = 0;
    @(negedge clk); sleep_strobe = 1'b0;
    check(proc_state == 3'd3 && periph_en && !cpu_run, "R5 sleep entry", 32'(proc_state), 32'd3);
    repeat (5) @(negedge clk);
    check(proc_state == 3'd3 && log_n == 0, "R5 sleep held, no access", 32'(log_n), 32'd0);

    // R8: bus grant from sleep, return to sleep
    bus_req = 1'b1;
    @(negedge clk);
    check(proc_state == 3'd5 && bus_grant, "R8 grant from SLEEP", 32'(proc_state), 32'd5);
    bus_req = 1'b0;
    @(negedge clk);
    check(proc_state == 3'd3 && !bus_grant, "R8 return to SLEEP", 32'(proc_state), 32'd3);

    // R7: interrupt wakes sleep without a boundary
    pc_r = $urandom; sr_r = $urandom;
    cur_pc = pc_r; cur_sr = sr_r; irq_vector = 6'd40; irq_pending = 1'b1;
    @(negedge clk);
    check(proc_state == 3'd1, "R7 wake from sleep", 32'(proc_state), 32'd1);
    irq_pending = 1'b0;
    wait_state(3'd2, "R7 back to RUN");
    verify_exc(40, pc_r, sr_r, "R7 sleep wake");

    // R6: standby, interrupts ignored, NMI edge wakes
    @(negedge clk); sby_bit = 1'b1; sleep_strobe = 1'b1;
    @(negedge clk); sleep_strobe = 1'b0; sby_bit = 1'b0;
    check(proc_state == 3'd4 && !periph_en, "R6 standby entry", {31'd0, periph_en}, 32'd0);
    log_n = 0; irq_pending = 1'b1; insn_boundary = 1'b1;
    repeat (4) @(negedge clk);
    check(proc_state == 3'd4 && log_n == 0 && !mem_req, "R6 irq ignored in standby", 32'(proc_state), 32'd4);
    irq_pending = 1'b0; insn_boundary = 1'b0;
    pc_r = $urandom; sr_r = $urandom; cur_pc = pc_r; cur_sr = sr_r;
    nmi_in = 1'b1;
    @(negedge clk);
    check(proc_state == 3'd1 && periph_en, "R6 NMI wakes standby", 32'(proc_state), 32'd1);
    nmi_in = 1'b0;
    wait_state(3'd2, "R6 back to RUN");
    verify_exc(NMI_VEC, pc_r, sr_r, "R6 nmi wake");

    // R8: bus request in RUN waits for a boundary
    @(negedge clk); bus_req = 1'b1;
    repeat (3) @(negedge clk);
    check(proc_state == 3'd2 && !bus_grant, "R8 no grant off boundary", 32'(bus_grant), 32'd0);
    insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
    check(proc_state == 3'd5 && bus_grant && !cpu_run, "R8 grant at boundary", 32'(proc_state), 32'd5);
    repeat (4) @(negedge clk);
    check(proc_state == 3'd5, "R8 release held", 32'(proc_state), 32'd5);
    bus_req = 1'b0;
    @(negedge clk);
    check(proc_state == 3'd2 && !bus_grant && cpu_run, "R8 return to RUN", 32'(proc_state), 32'd2);

    // R9: bus request raised during stacking is held off
    pc_r = $urandom; sr_r = $urandom;
    cur_pc = pc_r; cur_sr = sr_r; irq_vector = 6'd63; irq_pending = 1'b1; insn_boundary = 1'b1;
    log_n = 0;
    @(negedge clk);
    irq_pending = 1'b0; bus_req = 1'b1;
    bad = 0;
    for (int k = 0; k < 300 && proc_state == 3'd1; k++) begin
      if (bus_grant) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9 no grant during exception", 32'(bad), 32'd0);
    check(proc_state == 3'd2, "R9 RUN before grant", 32'(proc_state), 32'd2);
    verify_exc(63, pc_r, sr_r, "R9 stacking");
    @(negedge clk);
    check(proc_state == 3'd5 && bus_grant, "R9 grant after exception", 32'(proc_state), 32'd5);
    bus_req = 1'b0; insn_boundary = 1'b0;
    @(negedge clk);

    // R11: priority bus > interrupt > sleep
    bus_req = 1'b1; irq_pending = 1'b1; sleep_strobe = 1'b1; insn_boundary = 1'b1;
    irq_vector = 6'd5; log_n = 0;
    @(negedge clk);
    check(proc_state == 3'd5, "R11 bus wins", 32'(proc_state), 32'd5);
    irq_pending = 1'b0; sleep_strobe = 1'b0; insn_boundary = 1'b0; bus_req = 1'b0;
    @(negedge clk);
    check(proc_state == 3'd2 && log_n == 0, "R11 no exception taken", 32'(log_n), 32'd0);
    pc_r = $urandom; sr_r = $urandom; cur_pc = pc_r; cur_sr = sr_r;
    irq_vector = 6'd17; irq_pending = 1'b1; sleep_strobe = 1'b1; insn_boundary = 1'b1;
    @(negedge clk);
    check(proc_state == 3'd1, "R11 interrupt wins over sleep", 32'(proc_state), 32'd1);
    irq_pending = 1'b0; sleep_strobe = 1'b0; insn_boundary = 1'b0;
    wait_state(3'd2, "R11 back to RUN");
    verify_exc(17, pc_r, sr_r, "R11 irq");

    // R10: more random interrupts with random ack latency
    for (int i = 0; i < 6; i++) begin
      do_irq($urandom_range(0, 63), $urandom, $urandom, "R10 latency mix");
    end

    finish_run();
  end
endmodule